// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a processor that spends several clock cycles on each instruction and reaches a single memory for both instruction fetch and data access. It holds the program counter, an instruction register, a data register that captures memory read data, a 32-entry by 32-bit register file, two operand registers, the ALU and a register for its result. A multiplexer chooses the memory address: either the program counter or the stored ALU result. Other multiplexers choose the ALU operands, the next program counter, and the register-file write address and write data.

A separate control unit drives every strobe and select and supplies the ALU operation code. The datapath returns the opcode field, the function field and a zero flag so the controller can sequence the next step. The intermediate registers (operand pair, data register, ALU result register) are not visible to software. They exist only to carry values from one cycle of an instruction to the next.

Top module: `mc_datapath`

## Requirements
- R1: An active-low asynchronous reset clears the program counter, the instruction register, every holding register and all 32 register-file entries to zero.
- R2: The program counter takes a new value at a clock edge only while `pcLoad` is 1. Otherwise it keeps its value.
- R3: `memAddr` is the program counter when `addrSel` is 0 and the ALU result register when `addrSel` is 1.
- R4: The instruction register loads `memRdata` at a clock edge only while `irLoad` is 1. `opcode` is instruction bits 31:26 and `funct` is bits 5:0.
- R5: The register file is read at the entry named by instruction bits 25:21 (first operand) and bits 20:16 (second operand). Both read values enter the operand registers at every clock edge, and the second operand register drives `memWdata`. Entry 0 always reads as zero, even after a write to it.
- R6: When `rfWrite` is 1, the entry named by bits 20:16 (`rfDstSel`=0) or bits 15:11 (`rfDstSel`=1) is written at the clock edge. The written value is the ALU result register (`wbSel`=0) or the data register (`wbSel`=1). No other entry changes.
- R7: The second ALU operand is selected by `opBSel`: 00 selects the second operand register, 01 the constant 4, 10 the sign-extended bits 15:0, and 11 that sign-extended value shifted left by 2.
- R8: The first ALU operand is the program counter when `opASel` is 0 and the first operand register when `opASel` is 1.
- R9: The ALU applies the operation given by `aluCtl`: 010 add, 110 subtract, 000 bitwise and, 001 bitwise or, and 111 signed set-less-than, which yields 1 or 0.
- R10: `zero` is 1 exactly when the present ALU output equals zero.
- R11: When the program counter loads, its new value is selected by `pcNextSel`: 00 the present ALU output, 01 the ALU result register, 10 the jump target {PC[31:28], instruction[25:0], 2'b00}.
- R12: The data register, both operand registers and the ALU result register load at every clock edge, with no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pcLoad | input | 1 | Program counter load enable |
| addrSel | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| irLoad | input | 1 | Instruction register load enable |
| rfWrite | input | 1 | Register-file write enable |
| rfDstSel | input | 1 | Write address select: 0 bits 20:16, 1 bits 15:11 |
| wbSel | input | 1 | Write data select: 0 ALU result register, 1 data register |
| opASel | input | 1 | First ALU operand select: 0 PC, 1 operand register A |
| opBSel | input | 2 | Second ALU operand select |
| pcNextSel | input | 2 | Next program counter select |
| aluCtl | input | 3 | ALU operation code |
| memRdata | input | 32 | Read data from the shared memory |
| memAddr | output | 32 | Address to the shared memory |
| memWdata | output | 32 | Write data to the shared memory (operand register B) |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU output equals zero |

## Verification
The assertions assume that every control input has a known value from the first clock edge after reset. They also assume the controls change only between edges, and that `pcLoad` and `irLoad` are held at 0 while reset is active. The bench drives all controls to 0 through reset and changes them only just after the falling edge. The stimulus uses only the five defined ALU codes and the three defined next-PC selections. Random operand values are written into the register file through the data-register path. Random ALU operations are then checked both through `zero` and through the ALU result register, which the bench reads back on `memAddr`.

// File: rtl/mc_pkg.sv
package mc_pkg;
  parameter int unsigned XLEN    = 32;
  parameter int unsigned REG_CNT = 32;
  localparam int unsigned REG_AW = $clog2(REG_CNT);

  // instruction field positions
  localparam int unsigned OPC_LSB = 26;
  localparam int unsigned RS_LSB  = 21;
  localparam int unsigned RT_LSB  = 16;
  localparam int unsigned RD_LSB  = 11;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned IDX_W   = 26;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'b00,
    SRCB_FOUR = 2'b01,
    SRCB_IMM  = 2'b10,
    SRCB_IMMW = 2'b11
  } srcB_e;

  typedef enum logic [1:0] {
    PCN_ALU  = 2'b00,
    PCN_REG  = 2'b01,
    PCN_JUMP = 2'b10
  } pcNext_e;

  typedef struct packed {
    logic       pcLoad;
    logic       addrSel;
    logic       irLoad;
    logic       rfWrite;
    logic       rfDstSel;
    logic       wbSel;
    logic       opASel;
    logic [1:0] opBSel;
    logic [1:0] pcNextSel;
    logic [2:0] aluCtl;
  } dpCtrl_t;
endpackage

// File: rtl/mc_ldreg.sv
module mc_ldreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 32,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(N); i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  // entry 0 is hard-wired to zero on the read side
  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/mc_dpath.sv
module mc_dpath
  import mc_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned N  = REG_CNT,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtrl_t        ctrl,
  input  logic [W-1:0]   memRdata,
  output logic [W-1:0]   memAddr,
  output logic [W-1:0]   memWdata,
  output logic [FN_W-1:0] opcode,
  output logic [FN_W-1:0] funct,
  output logic           zero
);
  logic [W-1:0]  pcQ, pcNext;
  logic [W-1:0]  irQ;
  logic [W-1:0]  dataQ, aQ, bQ, aluOutQ;
  logic [W-1:0]  rdA, rdB;
  logic [W-1:0]  srcA, srcB, aluY;
  logic [W-1:0]  immSext, jumpTgt;
  logic [AW-1:0] rfWrAddr;
  logic [W-1:0]  rfWrData;

  // architectural and instruction state with load enables
  mc_ldreg #(.W(W)) u_pcReg (
    .clk(clk), .rstN(rstN), .en(ctrl.pcLoad), .d(pcNext), .q(pcQ));
  mc_ldreg #(.W(W)) u_irReg (
    .clk(clk), .rstN(rstN), .en(ctrl.irLoad), .d(memRdata), .q(irQ));

  // holding registers between cycles, loaded every edge
  mc_ldreg #(.W(W)) u_dataReg (
    .clk(clk), .rstN(rstN), .en(1'b1), .d(memRdata), .q(dataQ));
  mc_ldreg #(.W(W)) u_aReg (
    .clk(clk), .rstN(rstN), .en(1'b1), .d(rdA), .q(aQ));
  mc_ldreg #(.W(W)) u_bReg (
    .clk(clk), .rstN(rstN), .en(1'b1), .d(rdB), .q(bQ));
  mc_ldreg #(.W(W)) u_aluOutReg (
    .clk(clk), .rstN(rstN), .en(1'b1), .d(aluY), .q(aluOutQ));

  // register file
  assign rfWrAddr = ctrl.rfDstSel ? irQ[RD_LSB +: AW] : irQ[RT_LSB +: AW];
  assign rfWrData = ctrl.wbSel ? dataQ : aluOutQ;

  mc_regfile #(.W(W), .N(N)) u_rf (
    .clk(clk), .rstN(rstN),
    .rdAddrA(irQ[RS_LSB +: AW]), .rdAddrB(irQ[RT_LSB +: AW]),
    .rdDataA(rdA), .rdDataB(rdB),
    .wrEn(ctrl.rfWrite), .wrAddr(rfWrAddr), .wrData(rfWrData));

  // operand selection
  assign immSext = {{(W-IMM_W){irQ[IMM_W-1]}}, irQ[IMM_W-1:0]};
  assign srcA    = ctrl.opASel ? aQ : pcQ;

  always_comb begin
    case (ctrl.opBSel)
      SRCB_REG:  srcB = bQ;
      SRCB_FOUR: srcB = W'(4);
      SRCB_IMM:  srcB = immSext;
      default:   srcB = immSext << 2;
    endcase
  end

  mc_alu #(.W(W)) u_alu (
    .a(srcA), .b(srcB), .op(ctrl.aluCtl), .y(aluY), .zero(zero));

  // next program counter
  assign jumpTgt = {pcQ[W-1:IDX_W+2], irQ[IDX_W-1:0], 2'b00};

  always_comb begin
    case (ctrl.pcNextSel)
      PCN_ALU:  pcNext = aluY;
      PCN_REG:  pcNext = aluOutQ;
      PCN_JUMP: pcNext = jumpTgt;
      default:  pcNext = aluY;
    endcase
  end

  // shared memory port
  assign memAddr  = ctrl.addrSel ? aluOutQ : pcQ;
  assign memWdata = bQ;

  assign opcode = irQ[OPC_LSB +: FN_W];
  assign funct  = irQ[FN_W-1:0];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            pcLoad,
  input  logic            addrSel,
  input  logic            irLoad,
  input  logic            rfWrite,
  input  logic            rfDstSel,
  input  logic            wbSel,
  input  logic            opASel,
  input  logic [1:0]      opBSel,
  input  logic [1:0]      pcNextSel,
  input  logic [2:0]      aluCtl,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic [FN_W-1:0] opcode,
  output logic [FN_W-1:0] funct,
  output logic            zero
);
  dpCtrl_t ctrl;

  always_comb begin
    ctrl.pcLoad    = pcLoad;
    ctrl.addrSel   = addrSel;
    ctrl.irLoad    = irLoad;
    ctrl.rfWrite   = rfWrite;
    ctrl.rfDstSel  = rfDstSel;
    ctrl.wbSel     = wbSel;
    ctrl.opASel    = opASel;
    ctrl.opBSel    = opBSel;
    ctrl.pcNextSel = pcNextSel;
    ctrl.aluCtl    = aluCtl;
  end

  mc_dpath #(.W(XLEN), .N(REG_CNT)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .opcode(opcode), .funct(funct), .zero(zero));
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk
  import mc_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            pcLoad,
  input logic            addrSel,
  input logic            irLoad,
  input logic [XLEN-1:0] memRdata,
  input logic [XLEN-1:0] memAddr,
  input logic [FN_W-1:0] opcode,
  input logic [FN_W-1:0] funct,
  input logic            zero
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2: without a load strobe the PC shown on the address port stays put
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(pcLoad) && !$past(addrSel) && !addrSel)
      |-> (memAddr == $past(memAddr)));

  // R4: instruction fields hold when the load strobe was low
  p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(irLoad)) |-> (opcode == $past(opcode) && funct == $past(funct)));

  // R4: instruction fields follow the memory word captured at the last edge
  p_ir_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(irLoad))
      |-> (opcode == $past(memRdata[31:26]) && funct == $past(memRdata[5:0])));

  // R10 and R12: stored ALU result is zero exactly when the flag was set
  p_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && addrSel) |-> ((memAddr == '0) == $past(zero)));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk(clk), .rstN(rstN), .pcLoad(pcLoad), .addrSel(addrSel),
  .irLoad(irLoad), .memRdata(memRdata), .memAddr(memAddr),
  .opcode(opcode), .funct(funct), .zero(zero));

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pcLoad, addrSel, irLoad, rfWrite, rfDstSel, wbSel, opASel;
  logic [1:0]  opBSel, pcNextSel;
  logic [2:0]  aluCtl;
  logic [31:0] memRdata;
  logic [31:0] memAddr, memWdata;
  logic [5:0]  opcode, funct;
  logic        zero;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [31:0] regModel [32];
  logic [31:0] pcModel;

  mc_datapath u_dut (
    .clk(clk), .rstN(rstN), .pcLoad(pcLoad), .addrSel(addrSel),
    .irLoad(irLoad), .rfWrite(rfWrite), .rfDstSel(rfDstSel), .wbSel(wbSel),
    .opASel(opASel), .opBSel(opBSel), .pcNextSel(pcNextSel), .aluCtl(aluCtl),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .opcode(opcode), .funct(funct), .zero(zero));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] aluModel(input logic [2:0] op, input logic [31:0] a, b);
    case (op)
      3'b000: return a & b;
      3'b001: return a | b;
      3'b010: return a + b;
      3'b110: return a - b;
      3'b111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [31:0] mkInstr(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] low);
    return {op, rs, rt, low};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic clearCtl;
    pcLoad = 0; addrSel = 0; irLoad = 0; rfWrite = 0; rfDstSel = 0; wbSel = 0;
    opASel = 0; opBSel = 2'b00; pcNextSel = 2'b00; aluCtl = 3'b000;
  endtask

  task automatic loadIr(input logic [31:0] word);
    memRdata = word;
    irLoad = 1;
    step();
    irLoad = 0;
  endtask

  // value enters through the data register, written at rt; rd field names 31
  task automatic writeReg(input logic [4:0] idx, input logic [31:0] val);
    loadIr(mkInstr(6'h23, 5'd0, idx, {5'd31, 11'h0}));
    memRdata = val;
    step();
    wbSel = 1; rfWrite = 1;
    step();
    clearCtl();
    if (idx != 0) regModel[idx] = val;
  endtask

  task automatic readB(input logic [4:0] idx, output logic [31:0] val);
    loadIr(mkInstr(6'h00, 5'd0, idx, 16'h0));
    step();
    val = memWdata;
  endtask

  task automatic aluCheck(input logic [4:0] rs, rt, input logic [2:0] op, input string tag);
    logic [31:0] exp;
    loadIr(mkInstr(6'h00, rs, rt, 16'h0020));
    step();
    opASel = 1; opBSel = 2'b00; aluCtl = op;
    #1;
    exp = aluModel(op, regModel[rs], regModel[rt]);
    check({tag, " R10 zero"}, {31'd0, zero}, {31'd0, exp == 32'd0});
    step();
    addrSel = 1;
    #1;
    check({tag, " R9 result"}, memAddr, exp);
    clearCtl();
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] expv;
    logic [2:0]  ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) regModel[i] = 32'd0;
    pcModel = 32'd0;
    clearCtl();
    memRdata = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;

    // R1: reset state
    check("R1 memAddr", memAddr, 32'd0);
    check("R1 opcode", {26'd0, opcode}, 32'd0);
    check("R1 funct", {26'd0, funct}, 32'd0);
    check("R1 memWdata", memWdata, 32'd0);
    check("R10 zero after reset", {31'd0, zero}, 32'd1);
    readB(5'd17, got);
    check("R1 reg17 cleared", got, 32'd0);

    // R4: load and hold of the instruction register
    loadIr(32'h8C43_002B);
    check("R4 opcode load", {26'd0, opcode}, 32'h23);
    check("R4 funct load", {26'd0, funct}, 32'h2B);
    memRdata = 32'h0000_0015;
    step();
    check("R4 opcode hold", {26'd0, opcode}, 32'h23);
    check("R4 funct hold", {26'd0, funct}, 32'h2B);

    // R5, R6, R12: writes through the data register, reads through B
    writeReg(5'd3, 32'h1234_5678);
    readB(5'd3, got);
    check("R5 R12 read reg3", got, 32'h1234_5678);
    readB(5'd31, got);
    check("R6 rd untouched when rt selected", got, 32'd0);
    writeReg(5'd0, 32'hDEAD_BEEF);
    readB(5'd0, got);
    check("R5 reg0 reads zero", got, 32'd0);

    // R6: write to rd with ALU result register data
    writeReg(5'd2, 32'h0000_1000);
    loadIr(mkInstr(6'h00, 5'd3, 5'd0, {5'd9, 11'h020}));
    step();
    opASel = 1; opBSel = 2'b00; aluCtl = 3'b010;
    memRdata = 32'h5555_5555;
    step();
    rfDstSel = 1; rfWrite = 1; wbSel = 0;
    step();
    clearCtl();
    regModel[9] = regModel[3];
    readB(5'd9, got);
    check("R6 rd write from ALU result", got, 32'h1234_5678);
    readB(5'd0, got);
    check("R6 rt entry not written", got, 32'd0);

    // R7, R8: second operand choices with A as first operand
    loadIr(mkInstr(6'h08, 5'd2, 5'd3, 16'hFFF0));
    step();
    opASel = 1; aluCtl = 3'b010;
    opBSel = 2'b01; step(); addrSel = 1; #1;
    check("R7 A plus four", memAddr, 32'h0000_1004);
    addrSel = 0; opBSel = 2'b10; step(); addrSel = 1; #1;
    check("R7 A plus sext imm", memAddr, 32'h0000_1000 + sext(16'hFFF0));
    addrSel = 0; opBSel = 2'b11; step(); addrSel = 1; #1;
    check("R7 A plus sext imm x4", memAddr, 32'h0000_1000 + (sext(16'hFFF0) << 2));
    addrSel = 0; opBSel = 2'b00; step(); addrSel = 1; #1;
    check("R7 A plus B", memAddr, 32'h1234_6678);
    addrSel = 0; opASel = 0; opBSel = 2'b10; step(); addrSel = 1; #1;
    check("R8 PC plus sext imm", memAddr, pcModel + sext(16'hFFF0));
    clearCtl();

    // R2, R11: PC increment through the ALU output
    opASel = 0; opBSel = 2'b01; aluCtl = 3'b010; pcNextSel = 2'b00; pcLoad = 1;
    step();
    clearCtl();
    pcModel = pcModel + 4;
    #1;
    check("R11 pc from ALU output", memAddr, pcModel);
    opASel = 0; opBSel = 2'b01; aluCtl = 3'b010;
    step();
    clearCtl();
    #1;
    check("R2 pc holds without load", memAddr, pcModel);

    // R11: PC from ALU result register, then jump keeping the upper bits
    writeReg(5'd5, 32'hA000_1230);
    loadIr(mkInstr(6'h00, 5'd5, 5'd0, 16'h0));
    step();
    opASel = 1; opBSel = 2'b00; aluCtl = 3'b010;
    step();
    aluCtl = 3'b000; pcNextSel = 2'b01; pcLoad = 1;
    step();
    clearCtl();
    pcModel = 32'hA000_1230;
    #1;
    check("R11 pc from ALU result register", memAddr, pcModel);
    check("R3 address is pc", memAddr, 32'hA000_1230);
    loadIr({6'h02, 26'h0AB_CDEF});
    opASel = 1; opBSel = 2'b01; aluCtl = 3'b010; pcNextSel = 2'b10; pcLoad = 1;
    step();
    clearCtl();
    pcModel = {pcModel[31:28], 26'h0AB_CDEF, 2'b00};
    #1;
    check("R11 jump target", memAddr, pcModel);
    check("R4 opcode of jump", {26'd0, opcode}, 32'h02);
    check("R4 funct of jump", {26'd0, funct}, 32'h2F);

    // R9, R10: directed corner cases
    writeReg(5'd6, 32'h8000_0000);
    writeReg(5'd7, 32'h0000_0001);
    aluCheck(5'd6, 5'd7, 3'b111, "slt negative vs positive");
    aluCheck(5'd7, 5'd6, 3'b111, "slt positive vs negative");
    aluCheck(5'd7, 5'd7, 3'b110, "sub equal operands");
    aluCheck(5'd6, 5'd7, 3'b110, "sub wrap");
    aluCheck(5'd0, 5'd7, 3'b010, "add with reg0");
    aluCheck(5'd6, 5'd7, 3'b000, "and disjoint");
    aluCheck(5'd6, 5'd7, 3'b001, "or");

    // R9, R10, R5: constrained random operations
    for (int n = 0; n < 40; n++) begin
      logic [4:0]  rsI, rtI;
      logic [31:0] va, vb;
      rsI = 5'(1 + ($urandom % 7));
      rtI = 5'(8 + ($urandom % 7));
      va  = $urandom;
      vb  = ($urandom % 4 == 0) ? va : $urandom;
      writeReg(rsI, va);
      writeReg(rtI, vb);
      aluCheck(rsI, rtI, ops[$urandom % 5], "random");
      readB(rtI, expv);
      check("R5 random read back", expv, regModel[rtI]);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule